// File: doc/BRIEF.md
# Lowest-Priority Bus Yield Arbiter

This block sits beside the local bus sequencer of a processor and runs the three-wire handshake through which an external master borrows the shared bus. The local processor is always the lowest-priority master: whenever the active-low request line is asserted, the block offers the bus through an active-low grant. The request line may be a wired OR of several external masters. Choosing among those masters is done by external circuitry and is outside this block.

The grant is offered only at a safe point. The sequencer must report the end of an operand transfer, and no read-modify-write sequence may be in progress. The sequencer holds `xfer_end` high while it is idle, so an idle bus counts as a boundary. The external master claims the bus by asserting grant-acknowledge. It keeps that line low for its whole tenure. The block drops the grant a fixed time after the claim. It takes the bus back for the local side once grant-acknowledge is released and no request is pending. The `local_owns` output tells the sequencer whether it may start new cycles.

Both handshake inputs pass through a synchronizer before the state machine sees them. All timing below counts rising clock edges. Edge 1 is the first edge at which the pin value is captured.

Top module: `bus_yield_arbiter`

## Requirements
- R1: While `rst_n` is low, `bus_grant_n` is 1 and `local_owns` is 1, whatever the other inputs do.
- R2: `bus_grant_n` goes low only in response to a request. With the bus at a boundary, `bus_req_n` held low from edge 1 makes `bus_grant_n` low and `local_owns` 0 after edge 3.
- R3: A request seen while `xfer_end` is 0 waits, and the local side keeps the bus. The grant is issued at the first edge that samples `xfer_end` high.
- R4: While `rmw_active` is 1, no grant is issued, even when `xfer_end` is 1. The grant follows at the first edge that samples `rmw_active` low with `xfer_end` high.
- R5: If the request is withdrawn before any grant-acknowledge, `bus_grant_n` returns to 1 and `local_owns` to 1 after edge 3, counted from the first edge that samples `bus_req_n` high.
- R6: While no grant is out, `bus_gack_n` has no effect: `local_owns` stays 1 and `bus_grant_n` stays 1.
- R7: After `bus_gack_n` goes low while the grant is out, `bus_grant_n` stays low through edge 4 and is high after edge 5. `local_owns` stays 0 for the whole tenure.
- R8: After `bus_gack_n` returns high with `bus_req_n` high, `local_owns` is 1 after edge 3, and `bus_grant_n` stays 1.
- R9: If a request is still pending when grant-acknowledge is released (wired-OR masters), the grant is reissued directly after edge 3. The local side does not take the bus in between.
- R10: `local_owns` is never 1 while `bus_grant_n` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req_n | input | 1 | Active-low bus request, possibly wired OR of several masters |
| bus_gack_n | input | 1 | Active-low grant-acknowledge from the master on the bus |
| xfer_end | input | 1 | Sequencer is at an operand boundary or idle |
| rmw_active | input | 1 | A read-modify-write sequence is in progress |
| bus_grant_n | output | 1 | Active-low bus grant |
| local_owns | output | 1 | Local sequencer owns the bus and may start cycles |

## Verification
The checker watches several rules on every cycle. It checks that grant and local ownership are never active together. It checks that a fresh grant only follows a synchronized request at an open boundary with no read-modify-write. It also checks the two-cycle grant tail after a takeover, and the outcome of withdrawal, release and hand-off. The checker only sees synchronized inputs, so the end-to-end latency from the pins is shown only by the bench's scenarios. The same holds for the real grant-acknowledge pin being ignored with no grant out, for a wired-OR request surviving a tenure, and for reset in the middle of a grant.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [1:0] {
    ST_LOCAL   = 2'd0,
    ST_WAIT    = 2'd1,
    ST_GRANTED = 2'd2,
    ST_EXTERN  = 2'd3
  } arb_state_e;

  // Cycles the grant lingers after the takeover is sampled.
  localparam int unsigned TAIL_CYCLES = 2;
  localparam int unsigned TAIL_W      = $clog2(TAIL_CYCLES + 1);

  // A grant may be offered only at an operand boundary outside read-modify-write.
  function automatic logic boundary_open(input logic at_end, input logic in_rmw);
    return at_end & ~in_rmw;
  endfunction

  function automatic logic [TAIL_W-1:0] tail_step(input logic load,
                                                  input logic [TAIL_W-1:0] cnt);
    if (load)
      return TAIL_W'(TAIL_CYCLES);
    else if (cnt != '0)
      return cnt - 1'b1;
    else
      return '0;
  endfunction

  function automatic logic local_side(input arb_state_e s);
    return (s == ST_LOCAL) || (s == ST_WAIT);
  endfunction

endpackage

// File: rtl/arb_sync.sv
module arb_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[0] <= '0;
        else        pipe[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= '0;
        else        pipe[s] <= pipe[s-1];
      end
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
  import arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_s,
  input  logic       gack_s,
  input  logic       bnd_ok,
  output arb_state_e st,
  output logic       ev_takeover
);

  arb_state_e st_nxt;

  assign ev_takeover = (st == ST_GRANTED) && gack_s;

  always_comb begin
    st_nxt = st;
    unique case (st)
      ST_LOCAL: begin
        if (req_s) st_nxt = bnd_ok ? ST_GRANTED : ST_WAIT;
      end
      ST_WAIT: begin
        if (!req_s)      st_nxt = ST_LOCAL;
        else if (bnd_ok) st_nxt = ST_GRANTED;
      end
      ST_GRANTED: begin
        if (gack_s)      st_nxt = ST_EXTERN;
        else if (!req_s) st_nxt = ST_LOCAL;
      end
      ST_EXTERN: begin
        if (!gack_s) st_nxt = req_s ? ST_GRANTED : ST_LOCAL;
      end
      default: st_nxt = ST_LOCAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_LOCAL;
    else        st <= st_nxt;
  end

endmodule

// File: rtl/arb_tail.sv
module arb_tail
  import arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic active
);

  logic [TAIL_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= tail_step(load, cnt);
  end

  assign active = (cnt != '0);

endmodule

// File: rtl/bus_yield_arbiter.sv
module bus_yield_arbiter
  import arb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_req_n,
  input  logic bus_gack_n,
  input  logic xfer_end,
  input  logic rmw_active,
  output logic bus_grant_n,
  output logic local_owns
);

  logic [1:0] sync_q;
  logic       req_s;
  logic       gack_s;
  logic       bnd_ok;
  logic       ev_takeover;
  logic       tail_on;
  arb_state_e st;

  arb_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({~bus_gack_n, ~bus_req_n}),
    .q     (sync_q)
  );

  assign req_s  = sync_q[0];
  assign gack_s = sync_q[1];
  assign bnd_ok = boundary_open(xfer_end, rmw_active);

  arb_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_s       (req_s),
    .gack_s      (gack_s),
    .bnd_ok      (bnd_ok),
    .st          (st),
    .ev_takeover (ev_takeover)
  );

  arb_tail u_tail (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (ev_takeover),
    .active (tail_on)
  );

  assign bus_grant_n = ~((st == ST_GRANTED) | tail_on);
  assign local_owns  = local_side(st);

endmodule

// File: rtl/arb_chk.sv
module arb_chk
  import arb_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       req_s,
  input logic       gack_s,
  input logic       xfer_end,
  input logic       rmw_active,
  input logic       ev_takeover,
  input arb_state_e st,
  input logic       bus_grant_n,
  input logic       local_owns
);

  assert_grant_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bus_grant_n) && $past(local_owns)) |-> $past(req_s));

  assert_grant_at_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bus_grant_n) && $past(local_owns)) |-> $past(xfer_end));

  assert_no_grant_in_rmw_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bus_grant_n) && $past(local_owns)) |-> !$past(rmw_active));

  assert_withdraw_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_GRANTED && !gack_s && !req_s) |=> (bus_grant_n && local_owns));

  assert_idle_stays_local_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LOCAL && !req_s) |=> (local_owns && bus_grant_n));

  assert_grant_tail_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_takeover |=> !bus_grant_n ##1 !bus_grant_n ##1 bus_grant_n);

  assert_tenure_not_local_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_EXTERN && gack_s) |=> !local_owns);

  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_EXTERN && !gack_s && !req_s) |=> local_owns);

  assert_handoff_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_EXTERN && !gack_s && req_s) |=> (!bus_grant_n && !local_owns));

  assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_grant_n |-> !local_owns);

endmodule

bind bus_yield_arbiter arb_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_s       (req_s),
  .gack_s      (gack_s),
  .xfer_end    (xfer_end),
  .rmw_active  (rmw_active),
  .ev_takeover (ev_takeover),
  .st          (st),
  .bus_grant_n (bus_grant_n),
  .local_owns  (local_owns)
);

// File: tb/sim_bus_yield_arbiter.sv
module sim_bus_yield_arbiter;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 15;

  // {bus_req_n, bus_gack_n, xfer_end, rmw_active, exp_grant_n, exp_owns}
  localparam logic [5:0] VEC [NVEC] = '{
    6'b111011, // 0 idle
    6'b010011, // 1 request mid-transfer (R3)
    6'b010011, // 2
    6'b010011, // 3 request seen, no boundary: waits (R3)
    6'b011111, // 4 boundary but rmw active (R4)
    6'b011000, // 5 boundary, rmw clear: grant (R2, R4)
    6'b001000, // 6 gack asserted
    6'b101000, // 7 request dropped with gack
    6'b101000, // 8 takeover sampled (R7)
    6'b101000, // 9 grant tail
    6'b101010, // 10 grant negated (R7)
    6'b111010, // 11 gack released
    6'b111010, // 12
    6'b111011, // 13 local resumes (R8)
    6'b111011  // 14
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_req_n = 1'b1;
  logic bus_gack_n = 1'b1;
  logic xfer_end = 1'b1;
  logic rmw_active = 1'b0;
  logic bus_grant_n;
  logic local_owns;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_yield_arbiter u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_req_n   (bus_req_n),
    .bus_gack_n  (bus_gack_n),
    .xfer_end    (xfer_end),
    .rmw_active  (rmw_active),
    .bus_grant_n (bus_grant_n),
    .local_owns  (local_owns)
  );

  function automatic string row_tag(input int i);
    case (i)
      1, 2, 3: return "R3";
      4:       return "R4";
      5, 6, 7: return "R2";
      8, 9, 10, 11, 12: return "R7";
      13, 14:  return "R8";
      default: return "R1";
    endcase
  endfunction

  task automatic drive(input logic r, input logic g, input logic x, input logic m);
    @(negedge clk);
    bus_req_n  = r;
    bus_gack_n = g;
    xfer_end   = x;
    rmw_active = m;
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic check(input string tag, input string what,
                       input logic exp_g, input logic exp_o);
    n_checks++;
    if (bus_grant_n !== exp_g || local_owns !== exp_o) begin
      n_fail++;
      $display("FAIL %s %s: grant_n=%b owns=%b expected grant_n=%b owns=%b",
               tag, what, bus_grant_n, local_owns, exp_g, exp_o);
    end
  endtask

  initial begin
    // R1: reset state, with hostile inputs
    bus_req_n = 1'b0;
    bus_gack_n = 1'b0;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    check("R1", "during reset", 1'b1, 1'b1);
    @(negedge clk);
    bus_req_n = 1'b1;
    bus_gack_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2]);
      check(row_tag(i), $sformatf("table row %0d", i), VEC[i][1], VEC[i][0]);
    end

    // R6: grant-acknowledge with no grant out is ignored
    for (int c = 0; c < 4; c++) begin
      drive(1'b1, 1'b0, 1'b1, 1'b0);
      check("R6", $sformatf("stray gack cycle %0d", c), 1'b1, 1'b1);
    end
    for (int c = 0; c < 3; c++) drive(1'b1, 1'b1, 1'b1, 1'b0);
    check("R6", "after stray gack", 1'b1, 1'b1);

    // R5: request withdrawn before acknowledge
    drive(1'b0, 1'b1, 1'b1, 1'b0);
    drive(1'b0, 1'b1, 1'b1, 1'b0);
    drive(1'b0, 1'b1, 1'b1, 1'b0);
    check("R2", "grant after third edge", 1'b0, 1'b0);
    drive(1'b1, 1'b1, 1'b1, 1'b0);
    drive(1'b1, 1'b1, 1'b1, 1'b0);
    check("R5", "grant held until withdrawal seen", 1'b0, 1'b0);
    drive(1'b1, 1'b1, 1'b1, 1'b0);
    check("R5", "withdrawal returns bus", 1'b1, 1'b1);

    // R9: second master keeps request low across the tenure
    drive(1'b0, 1'b1, 1'b1, 1'b0);
    drive(1'b0, 1'b1, 1'b1, 1'b0);
    drive(1'b0, 1'b1, 1'b1, 1'b0);
    check("R2", "grant for wired-OR request", 1'b0, 1'b0);
    for (int c = 0; c < 5; c++) drive(1'b0, 1'b0, 1'b1, 1'b0);
    check("R7", "tail expired during tenure", 1'b1, 1'b0);
    drive(1'b0, 1'b1, 1'b1, 1'b0);
    drive(1'b0, 1'b1, 1'b1, 1'b0);
    check("R9", "release not yet seen", 1'b1, 1'b0);
    drive(1'b0, 1'b1, 1'b1, 1'b0);
    check("R9", "grant reissued without local tenure", 1'b0, 1'b0);
    check("R10", "owns low while granted", 1'b0, 1'b0);

    // R1: reset in the middle of a grant
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", "reset during grant", 1'b1, 1'b1);
    bus_req_n = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    drive(1'b1, 1'b1, 1'b1, 1'b0);
    check("R1", "idle after reset", 1'b1, 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule